// File: doc/BRIEF.md
# Resistive Touch Auto-Measurement Sequencer

The block drives repeated position measurements of a resistive touch panel. It runs from a slow timing tick. Each pass settles the panel and converts the X axis. It then settles again and converts the Y axis. Three further programmable wait phases follow before the next pass begins. Conversions go to an external ADC through a request/done handshake, and the block does not model the analog side.

Each completed X/Y pair is packed into a 32-bit word together with the pen level, which is sampled when the Y conversion finishes. The word is pushed into a small sample FIFO. Software programs the wait lengths and the control bits through a simple register port. It reads status flags there and pops samples by reading the data register. An interrupt follows the FIFO fill level: it asserts either at four entries or at one entry, as software selects.

Top module: `touch_seq`

## Requirements
- R1: After reset the FIFO is empty with no overrun, `irq_o` and `adc_req_o` are low, control reads 0, and the settle/gap/hold/rest registers read 2, 4, 16 and 88.
- R2: While auto-capture runs, conversions alternate X then Y (`adc_axis_o` 0 = X, 1 = Y). A request stays high with its axis stable until `adc_done_i` is seen.
- R3: Each pass runs settle, X conversion, settle, Y conversion, gap, hold, rest, in that order. A wait phase programmed to N lasts N ticks, and N = 0 lasts one tick.
- R4: Wait phases advance only on clock cycles with `tick_i` high.
- R5: A FIFO word has bit 31 = pen level (1 = pen up), bits 25:16 = X, bits 9:0 = Y, and all other bits 0. The pen level is taken in the cycle the Y conversion completes.
- R6: Reading register 2 returns the oldest entry and removes it. Reading it when empty returns 0 and changes nothing.
- R7: Register 0 reports FIFO empty at bit 7 and overrun at bit 8. All other bits are 0.
- R8: A pair completed while the FIFO is full is dropped and sets the sticky overrun flag. The flag clears only when a read leaves the FIFO empty.
- R9: With control bit 11 set, `irq_o` is high while the FIFO holds 4 or more entries. With bit 11 clear, it is high while the FIFO holds at least one entry.
- R10: Control register 1 holds auto-enable (bit 0), power-up (bit 2) and interrupt-level select (bit 11), and reads them back. Clearing bit 0 stops the sequencer at the next phase boundary with no partial pair pushed.
- R11: Registers 3 (settle), 4 (gap), 5 (hold) and 6 (rest) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow timing tick, one cycle wide |
| pen_up_i | input | 1 | Pen level from the panel, 1 = up |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on the data register) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| adc_req_o | output | 1 | Conversion request, held until done |
| adc_axis_o | output | 1 | Axis of the requested conversion, 0 = X, 1 = Y |
| adc_done_i | input | 1 | Conversion done, one cycle wide |
| adc_data_i | input | 10 | Conversion result, valid with done |
| irq_o | output | 1 | FIFO level interrupt |

## Verification
A Y-done accepted at a clock edge pushes the word at that same edge. The empty flag, the overrun flag and `irq_o` are therefore due one clock after the done pulse. A data read is combinational before its edge, and the pop is visible after that edge. A wait of N ticks under a constant tick ends N edges after the phase is entered. So the spacing from a done pulse to the next request is a known cycle count, and the bench measures it against the programmed values. The bench drives inputs one nanosecond after each rising edge and samples on the falling edge. Its queue model is updated at every rising edge and compared with status and `irq_o` on every falling edge.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETTLE_X, PH_CONV_X, PH_SETTLE_Y, PH_CONV_Y, PH_GAP, PH_HOLD, PH_REST
  } phase_e;

  localparam logic [3:0] A_STAT   = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_DATA   = 4'd2;
  localparam logic [3:0] A_SETTLE = 4'd3;
  localparam logic [3:0] A_GAP    = 4'd4;
  localparam logic [3:0] A_HOLD   = 4'd5;
  localparam logic [3:0] A_REST   = 4'd6;

  localparam int STAT_EMPTY = 7;
  localparam int STAT_OVR   = 8;
  localparam int CTRL_AUTO  = 0;
  localparam int CTRL_PWR   = 2;
  localparam int CTRL_LVL   = 11;

  localparam int PEN_BIT = 31;
  localparam int X_LSB   = 16;
  localparam int Y_LSB   = 0;

  localparam int DEF_SETTLE = 2;
  localparam int DEF_GAP    = 4;
  localparam int DEF_HOLD   = 16;
  localparam int DEF_REST   = 88;
endpackage

// File: rtl/touch_seq_phase.sv
module touch_seq_phase
  import touch_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SMP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] rest_i,
  input  logic             adc_done_i,
  input  logic [SMP_W-1:0] adc_data_i,
  output logic             adc_req_o,
  output logic             adc_axis_o,
  output logic             pair_valid_o,
  output logic [SMP_W-1:0] pair_x_o,
  output logic [SMP_W-1:0] pair_y_o
);
  phase_e ph_q, ph_d, ph_succ;
  logic [CNT_W-1:0] cnt_q, delay_sel;
  logic [CNT_W:0]   cnt_nx;
  logic [SMP_W-1:0] x_q;
  logic is_delay, is_conv, delay_end, step;

  always_comb begin
    is_delay  = 1'b1;
    delay_sel = settle_i;
    ph_succ   = PH_SETTLE_X;
    case (ph_q)
      PH_SETTLE_X: ph_succ = PH_CONV_X;
      PH_CONV_X:   begin is_delay = 1'b0; ph_succ = PH_SETTLE_Y; end
      PH_SETTLE_Y: ph_succ = PH_CONV_Y;
      PH_CONV_Y:   begin is_delay = 1'b0; ph_succ = PH_GAP; end
      PH_GAP:      begin delay_sel = gap_i;  ph_succ = PH_HOLD; end
      PH_HOLD:     begin delay_sel = hold_i; ph_succ = PH_REST; end
      PH_REST:     begin delay_sel = rest_i; ph_succ = PH_SETTLE_X; end
      default:     is_delay = 1'b0;
    endcase
  end

  assign cnt_nx    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // zero-length wait still consumes one tick
  assign delay_end = is_delay && tick_i && (cnt_nx >= {1'b0, delay_sel});
  assign is_conv   = (ph_q == PH_CONV_X) || (ph_q == PH_CONV_Y);
  assign step      = delay_end || (is_conv && adc_done_i) || (ph_q == PH_IDLE);
  assign ph_d      = step ? (run_i ? ph_succ : PH_IDLE) : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      x_q   <= '0;
    end else begin
      ph_q <= ph_d;
      if (step)                  cnt_q <= '0;
      else if (is_delay && tick_i) cnt_q <= cnt_nx[CNT_W-1:0];
      if (ph_q == PH_CONV_X && adc_done_i) x_q <= adc_data_i;
    end
  end

  assign adc_req_o    = is_conv;
  assign adc_axis_o   = (ph_q == PH_CONV_Y);
  assign pair_valid_o = (ph_q == PH_CONV_Y) && adc_done_i;
  assign pair_x_o     = x_q;
  assign pair_y_o     = adc_data_i;
endmodule

// File: rtl/touch_seq_fifo.sv
module touch_seq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovr_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q, pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok) wr_q <= nxt(wr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
      if (push_i && !push_ok)                          ovr_q <= 1'b1;
      else if (pop_ok && !push_i && cnt_q == CNT_W'(1)) ovr_q <= 1'b0;
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/touch_seq_regs.sv
module touch_seq_regs
  import touch_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [31:0]      fifo_head_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_ovr_i,
  output logic             pop_o,
  output logic             auto_o,
  output logic             lvl_o,
  output logic [CNT_W-1:0] settle_o,
  output logic [CNT_W-1:0] gap_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] rest_o
);
  logic auto_q, pwr_q, lvl_q;
  logic [CNT_W-1:0] settle_q, gap_q, hold_q, rest_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q   <= 1'b0;
      pwr_q    <= 1'b0;
      lvl_q    <= 1'b0;
      settle_q <= CNT_W'(DEF_SETTLE);
      gap_q    <= CNT_W'(DEF_GAP);
      hold_q   <= CNT_W'(DEF_HOLD);
      rest_q   <= CNT_W'(DEF_REST);
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          auto_q <= wdata_i[CTRL_AUTO];
          pwr_q  <= wdata_i[CTRL_PWR];
          lvl_q  <= wdata_i[CTRL_LVL];
        end
        A_SETTLE: settle_q <= wdata_i[CNT_W-1:0];
        A_GAP:    gap_q    <= wdata_i[CNT_W-1:0];
        A_HOLD:   hold_q   <= wdata_i[CNT_W-1:0];
        A_REST:   rest_q   <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT: begin
        rdata_o[STAT_EMPTY] = fifo_empty_i;
        rdata_o[STAT_OVR]   = fifo_ovr_i;
      end
      A_CTRL: begin
        rdata_o[CTRL_AUTO] = auto_q;
        rdata_o[CTRL_PWR]  = pwr_q;
        rdata_o[CTRL_LVL]  = lvl_q;
      end
      A_DATA:   rdata_o = fifo_empty_i ? '0 : fifo_head_i;
      A_SETTLE: rdata_o[CNT_W-1:0] = settle_q;
      A_GAP:    rdata_o[CNT_W-1:0] = gap_q;
      A_HOLD:   rdata_o[CNT_W-1:0] = hold_q;
      A_REST:   rdata_o[CNT_W-1:0] = rest_q;
      default: ;
    endcase
  end

  assign pop_o    = re_i && (addr_i == A_DATA);
  assign auto_o   = auto_q;
  assign lvl_o    = lvl_q;
  assign settle_o = settle_q;
  assign gap_o    = gap_q;
  assign hold_o   = hold_q;
  assign rest_o   = rest_q;
endmodule

// File: rtl/touch_seq.sv
module touch_seq
  import touch_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SMP_W      = 10,
  parameter int FIFO_DEPTH = 8,
  parameter int IRQ_LEVEL  = 4,
  localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pen_up_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             adc_req_o,
  output logic             adc_axis_o,
  input  logic             adc_done_i,
  input  logic [SMP_W-1:0] adc_data_i,
  output logic             irq_o
);
  logic             auto_en, lvl_sel, fifo_pop, fifo_ovr, pair_valid;
  logic [CNT_W-1:0] settle, gap, hold, rest;
  logic [SMP_W-1:0] pair_x, pair_y;
  logic [31:0]      word, fifo_head;
  logic [FCW-1:0]   fifo_cnt;

  touch_seq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .fifo_head_i(fifo_head), .fifo_empty_i(fifo_cnt == '0), .fifo_ovr_i(fifo_ovr),
    .pop_o(fifo_pop), .auto_o(auto_en), .lvl_o(lvl_sel),
    .settle_o(settle), .gap_o(gap), .hold_o(hold), .rest_o(rest)
  );

  touch_seq_phase #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_phase (
    .clk_i, .rst_ni, .tick_i, .run_i(auto_en),
    .settle_i(settle), .gap_i(gap), .hold_i(hold), .rest_i(rest),
    .adc_done_i, .adc_data_i, .adc_req_o, .adc_axis_o,
    .pair_valid_o(pair_valid), .pair_x_o(pair_x), .pair_y_o(pair_y)
  );

  always_comb begin
    word                    = '0;
    word[PEN_BIT]           = pen_up_i;
    word[X_LSB +: SMP_W]    = pair_x;
    word[Y_LSB +: SMP_W]    = pair_y;
  end

  touch_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(pair_valid), .data_i(word), .pop_i(fifo_pop),
    .head_o(fifo_head), .cnt_o(fifo_cnt), .ovr_o(fifo_ovr)
  );

  assign irq_o = lvl_sel ? (fifo_cnt >= FCW'(IRQ_LEVEL)) : (fifo_cnt != '0);
endmodule

// File: rtl/touch_seq_chk.sv
module touch_seq_chk #(
  parameter int FIFO_DEPTH = 8,
  localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           adc_req_o,
  input logic           adc_axis_o,
  input logic           adc_done_i,
  input logic           irq_o,
  input logic           auto_en,
  input logic           fifo_pop,
  input logic           fifo_ovr,
  input logic [FCW-1:0] fifo_cnt
);
  p_req_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_done_i |=> adc_req_o && $stable(adc_axis_o));

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= FCW'(FIFO_DEPTH));

  p_ovr_when_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_ovr) |-> fifo_cnt == FCW'(FIFO_DEPTH));

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovr && !(fifo_pop && fifo_cnt == FCW'(1)) |=> fifo_ovr);

  p_irq_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> fifo_cnt != '0);

  p_stopped_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en && !adc_req_o |=> !adc_req_o);
endmodule

bind touch_seq touch_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_req_o(adc_req_o), .adc_axis_o(adc_axis_o),
  .adc_done_i(adc_done_i), .irq_o(irq_o), .auto_en(auto_en), .fifo_pop(fifo_pop),
  .fifo_ovr(fifo_ovr), .fifo_cnt(fifo_cnt)
);

// File: tb/touch_seq_test.sv
`timescale 1ns/100ps
module touch_seq_test;
  localparam int DEPTH = 8;
  localparam logic [3:0] A_STAT = 4'd0, A_CTRL = 4'd1, A_DATA = 4'd2,
                         A_SETTLE = 4'd3, A_GAP = 4'd4, A_HOLD = 4'd5, A_REST = 4'd6;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, pen_up_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_addr_i = A_STAT;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        adc_req_o, adc_axis_o, irq_o;
  logic        adc_done_i = 1'b0;
  logic [9:0]  adc_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  touch_seq uut (
    .clk_i, .rst_ni, .tick_i, .pen_up_i, .reg_we_i, .reg_re_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .adc_req_o, .adc_axis_o, .adc_done_i,
    .adc_data_i, .irq_o
  );

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  bit   ovr_m = 0, lvl_sh = 0, done_is_y = 0, x_flag = 0, have_y = 0, expect_y = 0, gap_en = 0;
  int   cyc = 0, t_done = 0, n_smp = 0, exp_settle_gap = 0, exp_loop_gap = 0;
  logic [9:0] x_m = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // reference queue model, updated on every rising edge
  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      q.delete();
      ovr_m = 0;
    end else begin
      bit pop_m, push_m;
      pop_m  = reg_re_i && reg_addr_i == A_DATA && q.size() != 0;
      push_m = adc_done_i && done_is_y;
      if (adc_done_i) begin
        t_done = cyc;
        if (!done_is_y) begin x_m = adc_data_i; x_flag = 1; expect_y = 1; end
        else begin have_y = 1; expect_y = 0; end
      end
      if (pop_m) void'(q.pop_front());
      if (push_m) begin
        if (q.size() < DEPTH) q.push_back({pen_up_i, 5'b0, x_m, 6'b0, adc_data_i});
        else ovr_m = 1;
      end else if (pop_m && q.size() == 0) ovr_m = 0;
    end
  end

  // ADC responder with phase-spacing checks
  always @(posedge clk_i) begin
    #1;
    if (adc_done_i) adc_done_i = 1'b0;
    else if (rst_ni && adc_req_o) begin
      chk(adc_axis_o == expect_y, "R2 axis order", adc_axis_o, expect_y);
      if (gap_en && adc_axis_o)
        chk(cyc - t_done == exp_settle_gap, "R3 settle before Y", cyc - t_done, exp_settle_gap);
      if (gap_en && !adc_axis_o && have_y)
        chk(cyc - t_done == exp_loop_gap, "R3 gap+hold+rest+settle", cyc - t_done, exp_loop_gap);
      n_smp++;
      adc_data_i = adc_axis_o ? 10'((n_smp * 91 + 700) % 1024) : 10'((n_smp * 37 + 5) % 1024);
      done_is_y  = adc_axis_o;
      if (adc_axis_o) pen_up_i = ~pen_up_i;
      adc_done_i = 1'b1;
    end
  end

  // per-cycle comparison of interrupt and status
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [31:0] es;
      bit ei;
      ei = lvl_sh ? (q.size() >= 4) : (q.size() >= 1);
      chk(irq_o == ei, "R9 irq level", irq_o, ei);
      if (reg_addr_i == A_STAT && !reg_we_i && !reg_re_i) begin
        es = '0;
        es[7] = (q.size() == 0);
        es[8] = ovr_m;
        chk(reg_rdata_o == es, "R7 R8 status flags", reg_rdata_o, es);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; reg_addr_i = A_STAT;
    if (a == A_CTRL) lvl_sh = d[11];
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_re_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    chk(reg_rdata_o == exp, req, reg_rdata_o, exp);
    @(posedge clk_i); #1;
    reg_re_i = 1'b0; reg_addr_i = A_STAT;
  endtask

  task automatic rd_data(input string req, output logic [31:0] got);
    logic [31:0] exp;
    reg_re_i = 1'b1; reg_addr_i = A_DATA;
    @(negedge clk_i);
    exp = (q.size() != 0) ? q[0] : 32'h0;
    got = reg_rdata_o;
    chk(got == exp, req, got, exp);
    @(posedge clk_i); #1;
    reg_re_i = 1'b0; reg_addr_i = A_STAT;
  endtask

  task automatic set_delays(input int s, input int g, input int h, input int r);
    wr(A_SETTLE, s); wr(A_GAP, g); wr(A_HOLD, h); wr(A_REST, r);
    exp_settle_gap = mx1(s);
    exp_loop_gap   = mx1(g) + mx1(h) + mx1(r) + mx1(s);
  endtask

  task automatic drain(input string req);
    logic [31:0] w;
    while (q.size() != 0) begin
      rd_data(req, w);
      chk(w[30:26] == 0 && w[15:10] == 0, "R5 unused word bits zero", w, w & 32'h83FF_03FF);
    end
    rd_data("R6 read of empty FIFO", w);
    rd(A_STAT, 32'h80, "R8 overrun cleared once drained");
  endtask

  initial begin
    int n_before;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!adc_req_o, "R1 no request after reset", adc_req_o, 0);
    chk(!irq_o, "R1 irq low after reset", irq_o, 0);
    @(posedge clk_i); #1;
    rd(A_STAT, 32'h80, "R1 status after reset");
    rd(A_CTRL, 32'h0, "R1 control after reset");
    rd(A_SETTLE, 2, "R1 settle default");
    rd(A_GAP, 4, "R1 gap default");
    rd(A_HOLD, 16, "R1 hold default");
    rd(A_REST, 88, "R1 rest default");

    // level-4 interrupt, nonzero waits, overrun
    set_delays(3, 2, 1, 5);
    rd(A_SETTLE, 3, "R11 settle readback");
    rd(A_GAP, 2, "R11 gap readback");
    rd(A_HOLD, 1, "R11 hold readback");
    rd(A_REST, 5, "R11 rest readback");
    gap_en = 1; have_y = 0; expect_y = 0;
    wr(A_CTRL, 32'h801);
    repeat (40) begin
      @(negedge clk_i);
      chk(!adc_req_o, "R4 no progress without tick", adc_req_o, 0);
    end
    @(posedge clk_i); #1;
    tick_i = 1'b1;
    while (!ovr_m) begin @(posedge clk_i); #1; end
    repeat (40) @(posedge clk_i); #1;
    rd(A_CTRL, 32'h801, "R10 control readback");
    wr(A_CTRL, 32'h800);
    repeat (60) @(posedge clk_i); #1;
    chk(!adc_req_o, "R10 stopped after auto cleared", adc_req_o, 0);
    chk(q.size() == DEPTH, "R8 full FIFO kept oldest entries", q.size(), DEPTH);
    drain("R6 R5 popped word");

    // zero-length waits, per-entry interrupt
    set_delays(0, 0, 0, 0);
    have_y = 0; expect_y = 0;
    wr(A_CTRL, 32'h1);
    while (q.size() < 3) begin @(posedge clk_i); #1; end
    wr(A_CTRL, 32'h0);
    repeat (30) @(posedge clk_i); #1;
    drain("R6 R5 popped word zero waits");

    // stop between X and Y: no partial pair
    set_delays(20, 0, 0, 0);
    have_y = 0; expect_y = 0; x_flag = 0;
    wr(A_CTRL, 32'h1);
    while (!x_flag) begin @(posedge clk_i); #1; end
    n_before = q.size();
    wr(A_CTRL, 32'h4);
    repeat (80) @(posedge clk_i); #1;
    chk(q.size() == n_before, "R10 no partial pair pushed", q.size(), n_before);
    chk(!adc_req_o, "R10 idle after mid-pass stop", adc_req_o, 0);
    rd(A_STAT, 32'h80, "R10 FIFO still empty");
    rd(A_CTRL, 32'h4, "R10 power bit readback");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog R1-all actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule